// File: doc/BRIEF.md
# Converter Sequencer with Result Arbitration

This block is the digital side of a successive-approximation analog-to-digital converter. Software programs it through a small register port: a mode register, a channel register, a read-only result register, a comparison-mode register and a 10-bit threshold. Once the start bit is set, the block issues a start strobe and the channel number to the converter. It times each conversion itself and samples the converter's 10-bit data bus when the conversion ends. It then starts the next conversion on the same channel, and keeps doing so while the start bit stays set.

A stabilisation counter, sized in clock cycles from the clock frequency and a settle time in microseconds, holds off every result until the analog front end has settled. The first result after a start issued with the front end still off is always thrown away. Each accepted result goes into the result register and raises a one-cycle completion interrupt.

When threshold comparison is on, the interrupt fires only if the result lies on the selected side of the threshold. This lets the block act as a supply monitor. If a software access lands in the same cycle as a result update, a fixed rule decides which one wins.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `conv_irq` and `conv_start` are low.
- R2: Register addresses are mode=0, channel=1, result=2, compare-mode=3, threshold=4.
  - Only mode bits 7, 5:3 and 0 are writable. Only channel bits 2:0 are writable, and channel bits 9:3 always read 0.
  - Only compare-mode bits 7 and 6 are writable. The threshold keeps 10 bits.
  - A write to the result address has no effect.
- R3: While mode bit 7 (start) is set, `conv_start` pulses for one cycle at each conversion start, and `conv_chan` carries the channel register value.
  - Consecutive pulses are BASE_CYC << mode[5:3] cycles apart.
- R4: The stabilisation count runs while the start bit or the enable bit (mode bit 0) is set, and clears when both are 0. Any conversion that ends before STAB_CYC counted cycles is discarded, with no result write and no interrupt.
- R5: When conversion starts from idle with the enable bit clear, the first conversion's result is discarded even if the stabilisation count has expired. The next conversion is accepted.
- R6: An accepted result appears in the result register, and `conv_irq` pulses for one cycle, in the cycle after the conversion ends.
- R7: If a result read (`bus_rd` at address 2) coincides with the end of a conversion, the read returns the old value. The new result and the interrupt appear one cycle later.
- R8: If a mode or channel write coincides with a result update, the result register is left unchanged and no interrupt is raised for that conversion.
- R9: Clearing the start bit in the middle of a conversion lets that conversion finish and write its result. No further `conv_start` follows.
- R10: With compare-mode bit 7 set and bit 6 clear, results are still written, but the interrupt fires only when result >= threshold.
- R11: With compare-mode bits 7 and 6 both set, the interrupt fires only when result < threshold.
- R12: With compare-mode bit 7 set and the enable bit clear, every result is discarded.
- R13: Clearing both the start and enable bits restarts the stabilisation count. After a fresh start, results are held off again for STAB_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for conflict resolution) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data for `bus_addr` (combinational) |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| conv_chan | output | 3 | Channel of the running conversion |
| conv_data | input | 10 | Converter result, sampled when a conversion ends |
| conv_irq | output | 1 | One-cycle conversion-end interrupt |

## Verification
The bench places a result read, and separately a channel write, exactly in the cycle a conversion ends.
- A design that arbitrates wrongly either returns the new value too early or loses it outright, or it updates the register and interrupts despite the write.

The bench separates the two discard rules by making the first conversion after an unenabled start end after the settle window has expired. A design that only waits out the settle window would accept that result.

Further directed cases cover the following; a wrong design would raise interrupts for out-of-range results or keep converting after stop:
- both comparison directions, including equality at the threshold;
- comparison with the front end off;
- stopping in mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned BUS_W  = 10;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CHAN_W = 3;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned CODE_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CHAN = 3'd1;
    localparam logic [ADDR_W-1:0] A_RES  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PFM  = 3'd3;
    localparam logic [ADDR_W-1:0] A_THR  = 3'd4;

    localparam logic [REG_W-1:0] MODE_MASK = 8'hB9;
    localparam logic [REG_W-1:0] PFM_MASK  = 8'hC0;

    localparam int unsigned MODE_START_BIT = 7;
    localparam int unsigned MODE_EN_BIT    = 0;
    localparam int unsigned MODE_CODE_LSB  = 3;
    localparam int unsigned PFM_CMP_BIT    = 7;
    localparam int unsigned PFM_BELOW_BIT  = 6;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  result,
    output logic [BUS_W-1:0]  rdata,
    output logic              start,
    output logic              enable,
    output logic [CODE_W-1:0] code,
    output logic [CHAN_W-1:0] chan,
    output logic              pf_cmp,
    output logic              pf_below,
    output logic [BUS_W-1:0]  thr,
    output logic              mc_wr,
    output logic              rd_res
);

    typedef struct packed {
        logic [REG_W-1:0]  mode;
        logic [CHAN_W-1:0] chan;
        logic [REG_W-1:0]  pfm;
        logic [BUS_W-1:0]  thr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (addr)
                A_MODE:  regs_d.mode = wdata[REG_W-1:0] & MODE_MASK;
                A_CHAN:  regs_d.chan = wdata[CHAN_W-1:0];
                A_PFM:   regs_d.pfm  = wdata[REG_W-1:0] & PFM_MASK;
                A_THR:   regs_d.thr  = wdata;
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (addr)
            A_MODE:  rdata = BUS_W'(regs_q.mode);
            A_CHAN:  rdata = BUS_W'(regs_q.chan);
            A_RES:   rdata = result;
            A_PFM:   rdata = BUS_W'(regs_q.pfm);
            A_THR:   rdata = regs_q.thr;
            default: rdata = '0;
        endcase
    end

    assign start    = regs_q.mode[MODE_START_BIT];
    assign enable   = regs_q.mode[MODE_EN_BIT];
    assign code     = regs_q.mode[MODE_CODE_LSB +: CODE_W];
    assign chan     = regs_q.chan;
    assign pf_cmp   = regs_q.pfm[PFM_CMP_BIT];
    assign pf_below = regs_q.pfm[PFM_BELOW_BIT];
    assign thr      = regs_q.thr;
    assign mc_wr    = wr_en && ((addr == A_MODE) || (addr == A_CHAN));
    assign rd_res   = rd_en && (addr == A_RES);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned STAB_CYC = 700,
    parameter int unsigned BASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    input  logic [CHAN_W-1:0] chan,
    input  logic              pf_cmp,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              done_ok,
    output logic              stab_ok
);

    localparam int unsigned MAX_CYC = BASE_CYC << ((1 << CODE_W) - 1);
    localparam int unsigned TMR_W   = $clog2(MAX_CYC);
    localparam int unsigned STAB_W  = $clog2(STAB_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [TMR_W-1:0]  timer;
        logic [STAB_W-1:0] stab;
        logic              first_bad;
        logic              pulse;
        logic [CHAN_W-1:0] cchan;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [TMR_W:0]   len_full;
    logic [TMR_W-1:0] timer_load;
    logic             conv_end;

    always_comb begin
        len_full   = (TMR_W + 1)'(BASE_CYC) << code;
        timer_load = TMR_W'(len_full - 1'b1);
    end

    assign stab_ok  = (fsm_q.stab == STAB_W'(STAB_CYC));
    assign conv_end = (fsm_q.state == SEQ_CONV) && (fsm_q.timer == '0);
    assign done_ok  = conv_end && stab_ok && !fsm_q.first_bad && !(pf_cmp && !enable);

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.pulse = 1'b0;

        if (start || enable) begin
            if (!stab_ok) fsm_d.stab = fsm_q.stab + 1'b1;
        end else begin
            fsm_d.stab = '0;
        end

        unique case (fsm_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    fsm_d.state     = SEQ_CONV;
                    fsm_d.timer     = timer_load;
                    fsm_d.pulse     = 1'b1;
                    fsm_d.cchan     = chan;
                    fsm_d.first_bad = !enable;
                end
            end
            SEQ_CONV: begin
                if (fsm_q.timer != '0) begin
                    fsm_d.timer = fsm_q.timer - 1'b1;
                end else begin
                    fsm_d.first_bad = 1'b0;
                    if (start) begin
                        fsm_d.timer = timer_load;
                        fsm_d.pulse = 1'b1;
                        fsm_d.cchan = chan;
                    end else begin
                        fsm_d.state = SEQ_IDLE;
                    end
                end
            end
            default: fsm_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: SEQ_IDLE, default: '0};
        else        fsm_q <= fsm_d;
    end

    assign conv_start = fsm_q.pulse;
    assign conv_chan  = fsm_q.cchan;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_ok,
    input  logic [BUS_W-1:0] conv_data,
    input  logic             mc_wr,
    input  logic             rd_res,
    input  logic             pf_cmp,
    input  logic             pf_below,
    input  logic [BUS_W-1:0] thr,
    output logic [BUS_W-1:0] result,
    output logic             irq
);

    typedef struct packed {
        logic [BUS_W-1:0] res;
        logic             irq;
        logic             pend;
        logic [BUS_W-1:0] pval;
    } res_t;

    res_t res_d, res_q;

    logic             commit;
    logic [BUS_W-1:0] cval;
    logic             hit;

    always_comb begin
        res_d     = res_q;
        res_d.irq = 1'b0;
        commit    = 1'b0;
        cval      = res_q.pval;

        // A deferred result waits out a read, dies on a mode/channel write.
        if (res_q.pend) begin
            if (mc_wr) begin
                res_d.pend = 1'b0;
            end else if (!rd_res) begin
                commit     = 1'b1;
                res_d.pend = 1'b0;
            end
        end

        if (done_ok && !mc_wr) begin
            if (rd_res) begin
                res_d.pend = 1'b1;
                res_d.pval = conv_data;
            end else begin
                commit     = 1'b1;
                cval       = conv_data;
                res_d.pend = 1'b0;
            end
        end

        hit = pf_below ? (cval < thr) : (cval >= thr);
        if (commit) begin
            res_d.res = cval;
            res_d.irq = !pf_cmp || hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result = res_q.res;
    assign irq    = res_q.irq;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 50,
    parameter int unsigned STAB_US  = 14,
    parameter int unsigned BASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic [BUS_W-1:0]  conv_data,
    output logic              conv_irq
);

    localparam int unsigned STAB_CYC = CLK_MHZ * STAB_US;

    logic              start, enable, pf_cmp, pf_below;
    logic [CODE_W-1:0] code;
    logic [CHAN_W-1:0] chan;
    logic [BUS_W-1:0]  thr;
    logic [BUS_W-1:0]  res_val;
    logic              mc_wr, rd_res;
    logic              seq_done_ok, stab_ok;

    adc_seq_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .result   (res_val),
        .rdata    (bus_rdata),
        .start    (start),
        .enable   (enable),
        .code     (code),
        .chan     (chan),
        .pf_cmp   (pf_cmp),
        .pf_below (pf_below),
        .thr      (thr),
        .mc_wr    (mc_wr),
        .rd_res   (rd_res)
    );

    adc_seq_fsm #(
        .STAB_CYC (STAB_CYC),
        .BASE_CYC (BASE_CYC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .enable     (enable),
        .code       (code),
        .chan       (chan),
        .pf_cmp     (pf_cmp),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .done_ok    (seq_done_ok),
        .stab_ok    (stab_ok)
    );

    adc_seq_result result_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_ok   (seq_done_ok),
        .conv_data (conv_data),
        .mc_wr     (mc_wr),
        .rd_res    (rd_res),
        .pf_cmp    (pf_cmp),
        .pf_below  (pf_below),
        .thr       (thr),
        .result    (res_val),
        .irq       (conv_irq)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              conv_start,
    input logic              conv_irq,
    input logic              done_ok,
    input logic              mc_wr,
    input logic              rd_res,
    input logic              stab_ok,
    input logic [BUS_W-1:0]  result
);

    a_r2_chan_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CHAN) |-> (bus_rdata[BUS_W-1:CHAN_W] == '0));

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r4_irq_after_stab: assert property (@(posedge clk) disable iff (!rst_n)
        conv_irq |-> $past(stab_ok));

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_irq |=> !conv_irq);

    a_r7_read_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && rd_res && !mc_wr) |=> (!conv_irq && $stable(result)));

    a_r8_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && mc_wr) |=> (!conv_irq && $stable(result)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .conv_start (conv_start),
    .conv_irq   (conv_irq),
    .done_ok    (seq_done_ok),
    .mc_wr      (mc_wr),
    .rd_res     (rd_res),
    .stab_ok    (stab_ok),
    .result     (res_val)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    localparam int STAB = 100;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [9:0] bus_wdata = 10'd0;
    logic [9:0] bus_rdata;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic [9:0] conv_data = 10'd0;
    logic       conv_irq;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int start_cnt = 0;
    int irq_cnt = 0;
    int last_t = 0;
    int prev_t = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0] m_mode, m_pfm;
    logic [2:0] m_chan, m_cchan;
    int         m_thr, m_res, m_pval, m_stab, m_timer;
    logic       m_irq, m_pend, m_busy, m_first_bad, m_pulse;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.CLK_MHZ(50), .STAB_US(2), .BASE_CYC(BASE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .conv_data  (conv_data),
        .conv_irq   (conv_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_true(input string tag, input bit ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input logic [2:0] a);
        case (a)
            3'd0: return int'(m_mode);
            3'd1: return int'(m_chan);
            3'd2: return m_res;
            3'd3: return int'(m_pfm);
            3'd4: return m_thr;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pfm = 0; m_chan = 0; m_cchan = 0;
            m_thr = 0; m_res = 0; m_pval = 0; m_stab = 0; m_timer = 0;
            m_irq = 0; m_pend = 0; m_busy = 0; m_first_bad = 0; m_pulse = 0;
        end else begin
            automatic logic st     = m_mode[7];
            automatic logic en     = m_mode[0];
            automatic logic cmp    = m_pfm[7];
            automatic logic below  = m_pfm[6];
            automatic logic mc     = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1);
            automatic logic rr     = bus_rd && (bus_addr == 3'd2);
            automatic logic fin    = m_busy && (m_timer == 0);
            automatic logic accept = fin && (m_stab == STAB) && !m_first_bad && !(cmp && !en);
            automatic int   len    = BASE << m_mode[5:3];
            automatic logic commit = 0;
            automatic int   cv     = 0;
            m_irq = 0;
            if (m_pend) begin
                if (mc) m_pend = 0;
                else if (!rr) begin commit = 1; cv = m_pval; m_pend = 0; end
            end
            if (accept && !mc) begin
                if (rr) begin m_pend = 1; m_pval = int'(conv_data); end
                else begin commit = 1; cv = int'(conv_data); m_pend = 0; end
            end
            if (commit) begin
                m_res = cv;
                m_irq = !cmp || (below ? (cv < m_thr) : (cv >= m_thr));
            end
            m_pulse = 0;
            if (!m_busy) begin
                if (st) begin
                    m_busy = 1; m_timer = len - 1; m_pulse = 1; m_cchan = m_chan; m_first_bad = !en;
                end
            end else if (m_timer != 0) begin
                m_timer--;
            end else begin
                m_first_bad = 0;
                if (st) begin m_timer = len - 1; m_pulse = 1; m_cchan = m_chan; end
                else m_busy = 0;
            end
            if (st || en) begin
                if (m_stab < STAB) m_stab++;
            end else m_stab = 0;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_mode = bus_wdata[7:0] & 8'hB9;
                    3'd1: m_chan = bus_wdata[2:0];
                    3'd3: m_pfm  = bus_wdata[7:0] & 8'hC0;
                    3'd4: m_thr  = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (conv_start) begin start_cnt++; prev_t = last_t; last_t = cyc; end
            if (conv_irq) irq_cnt++;
            check("R6 rdata vs model", int'(bus_rdata), model_rd(bus_addr));
            check("R6 irq vs model", int'(conv_irq), int'(m_irq));
            check("R3 conv_start vs model", int'(conv_start), int'(m_pulse));
            check("R3 conv_chan vs model", int'(conv_chan), int'(m_cchan));
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = 10'(d);
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rdreg(input logic [2:0] a, output int v);
        @(negedge clk); #1;
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_end();
        do begin @(negedge clk); #1; end while (!(m_busy && m_timer == 0));
    endtask

    task automatic stop_all();
        wr(3'd0, 0);
        idle(300);
    endtask

    initial begin : main
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rdreg(3'(a), v);
            check("R1 register after reset", v, 0);
        end
        check("R1 irq after reset", int'(conv_irq), 0);
        check("R1 conv_start after reset", int'(conv_start), 0);

        // R2 register field masks
        wr(3'd0, 10'h07E); rdreg(3'd0, v); check("R2 mode mask", v, 'h38);
        wr(3'd0, 0);
        wr(3'd1, 10'h3FD); rdreg(3'd1, v); check("R2 channel reserved bits", v, 5);
        wr(3'd3, 10'h3FF); rdreg(3'd3, v); check("R2 compare-mode mask", v, 'hC0);
        wr(3'd3, 0);
        wr(3'd4, 10'h3FF); rdreg(3'd4, v); check("R2 threshold width", v, 'h3FF);
        wr(3'd4, 0);
        wr(3'd2, 10'h123); rdreg(3'd2, v); check("R2 result write ignored", v, 0);

        // R3 R4 R6 normal run on channel 5
        wr(3'd0, 'h01);
        idle(10);
        conv_data = 10'h155;
        wr(3'd0, 'h81);
        start_cnt = 0; irq_cnt = 0;
        idle(60);
        check("R4 no irq before settle", irq_cnt, 0);
        check_true("R4 conversions running", start_cnt >= 10, start_cnt, 10);
        idle(80);
        check_true("R6 irq after settle", irq_cnt > 0, irq_cnt, 1);
        rdreg(3'd2, v); check("R6 result value", v, 'h155);
        check("R3 channel output", int'(conv_chan), 5);
        check("R3 period code 0", last_t - prev_t, 4);
        wr(3'd0, 'h91);
        idle(60);
        check("R3 period code 2", last_t - prev_t, 16);

        // R7 read conflict
        wait_end();
        bus_rd = 1; bus_addr = 3'd2; conv_data = 10'h2AA;
        @(negedge clk);
        check("R7 irq deferred", int'(conv_irq), 0);
        check("R7 read returns old", int'(bus_rdata), 'h155);
        #1 bus_rd = 0;
        @(negedge clk);
        check("R7 irq one cycle later", int'(conv_irq), 1);
        check("R7 new result", int'(bus_rdata), 'h2AA);

        // R8 channel write conflict
        wait_end();
        bus_wr = 1; bus_addr = 3'd1; bus_wdata = 10'd5; conv_data = 10'h0F0;
        @(negedge clk);
        check("R8 no irq", int'(conv_irq), 0);
        #1 bus_wr = 0; bus_addr = 3'd2;
        @(negedge clk);
        check("R8 no irq later", int'(conv_irq), 0);
        check("R8 result unchanged", int'(bus_rdata), 'h2AA);

        // R9 stop mid-conversion
        do begin @(negedge clk); #1; end while (!(m_busy && m_timer == 5));
        bus_wr = 1; bus_addr = 3'd0; bus_wdata = 10'h001;
        @(negedge clk); #1 bus_wr = 0;
        start_cnt = 0; irq_cnt = 0;
        idle(40);
        check("R9 no restart", start_cnt, 0);
        check("R9 last conversion written", irq_cnt, 1);

        // R5 start without enable
        wr(3'd0, 0);
        idle(5);
        wr(3'd0, 'hB0);
        start_cnt = 0; irq_cnt = 0;
        idle(300);
        check("R5 first result dropped", irq_cnt, 0);
        check("R5 restarted", start_cnt, 2);
        idle(260);
        check("R5 second result kept", irq_cnt, 1);

        // R10 compare at or above
        stop_all();
        wr(3'd3, 'h80);
        wr(3'd4, 'h200);
        conv_data = 10'h100;
        wr(3'd0, 'h01);
        idle(120);
        wr(3'd0, 'h81);
        irq_cnt = 0;
        idle(100);
        check("R10 below threshold silent", irq_cnt, 0);
        rdreg(3'd2, v); check("R10 result still written", v, 'h100);
        conv_data = 10'h200;
        idle(40);
        check_true("R10 equal threshold fires", irq_cnt > 0, irq_cnt, 1);

        // R11 compare below
        wr(3'd3, 'hC0);
        idle(2);
        irq_cnt = 0;
        idle(40);
        check("R11 at threshold silent", irq_cnt, 0);
        conv_data = 10'h1FF;
        idle(40);
        check_true("R11 below threshold fires", irq_cnt > 0, irq_cnt, 1);

        // R12 compare with enable off
        conv_data = 10'h000;
        wr(3'd0, 'h80);
        idle(2);
        irq_cnt = 0;
        idle(60);
        check("R12 no irq", irq_cnt, 0);
        rdreg(3'd2, v); check("R12 result unchanged", v, 'h1FF);

        // R13 settle count restarts
        stop_all();
        wr(3'd3, 0);
        wr(3'd0, 'h81);
        idle(2);
        irq_cnt = 0;
        idle(60);
        check("R13 settle restarted", irq_cnt, 0);
        idle(100);
        check_true("R13 results resume", irq_cnt > 0, irq_cnt, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule